// File: doc/BRIEF.md
# Uniform-Word Line Compression Filter

This block sits on the write-back and refill path between a last-level cache and a DRAM controller. Every line that arrives from the cache is split into 32-bit words. If all the words are equal, the line is not sent to DRAM. The block keeps that one word, with a tag and a valid bit, in a small direct-mapped metadata table inside the block. A later read of that line is answered from the table: the response repeats the stored word across the full line, and DRAM sees no request.

A line whose words differ goes to DRAM unchanged, and any table entry for that address is dropped first. A uniform line may map to a slot that already holds another line. In that case the block first writes the older line to DRAM, rebuilt in full, and then replaces the slot.

The cache side and the DRAM side each have a valid/ready request channel and a valid/ready read-response channel. Addresses are line addresses. The block handles one request at a time.

Top module: `uwl_filter`

## Requirements
- R1: A line counts as uniform only when all 16 of its 32-bit words are equal. A line that differs in any single word, the first or the last included, is treated as non-uniform.
- R2: A uniform write produces no DRAM request when its table slot is empty or already holds the same tag. The slot is the line address modulo 32, and the tag is the remaining upper address bits. The stored word is updated, and a later read of that address returns the new line.
- R3: A read whose slot is valid and whose tag matches produces no DRAM request.
- R4: A table-hit read response carries all 16 words equal to the stored word. It becomes valid on the first cycle after the request is accepted.
- R5: A non-uniform write goes to DRAM with its address and data unchanged. If a valid entry with the same tag exists, that entry is cleared, so a later read of the address is fetched from DRAM.
- R6: A uniform write to a slot that holds a different tag first issues a DRAM write of the older line, rebuilt from its stored word, at the older line's address. The slot then takes the new tag and word, so the older address is afterwards read from DRAM.
- R7: A read that misses the table is forwarded to DRAM, and the DRAM response data is passed back to the cache unchanged.
- R8: After reset, the table holds no valid entry, the request channel is ready, and neither response nor DRAM request is valid.
- R9: While a DRAM request is pending, no new cache request is accepted. A DRAM request held back by a low ready keeps its valid, address and data stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req_valid | input | 1 | Cache request valid |
| up_req_ready | output | 1 | Cache request accepted this cycle when valid |
| up_req_write | input | 1 | 1 = write-back, 0 = read |
| up_req_addr | input | LA_W | Line address |
| up_req_data | input | WORD_W*WORDS | Write-back line |
| up_rsp_valid | output | 1 | Read response valid |
| up_rsp_ready | input | 1 | Cache takes the read response |
| up_rsp_data | output | WORD_W*WORDS | Read response line |
| dn_req_valid | output | 1 | DRAM request valid |
| dn_req_ready | input | 1 | DRAM controller takes the request |
| dn_req_write | output | 1 | 1 = write, 0 = read |
| dn_req_addr | output | LA_W | DRAM line address |
| dn_req_data | output | WORD_W*WORDS | DRAM write line |
| dn_rsp_valid | input | 1 | DRAM read data valid |
| dn_rsp_ready | output | 1 | Block takes the DRAM read data |
| dn_rsp_data | input | WORD_W*WORDS | DRAM read line |

## Verification
A table-hit response is due on the first cycle after acceptance. The bench counts cycles from the accepting edge and checks the cycle in which the response first becomes valid. Write results are judged only once the request channel is ready again, because every DRAM write the block owes has been handed over by then. The bench compares the DRAM model's write count, last address and last data at that point. Read results are taken at the response handshake, whatever the random ready timing on either side. The expected DRAM read count comes from the bench's own table model.

// File: rtl/uwl_pkg.sv
package uwl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FWD,
    ST_RSP,
    ST_DRD,
    ST_WAIT
  } uwl_state_e;
endpackage

// File: rtl/uwl_detect.sv
module uwl_detect #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WORDS  = 16,
  localparam int unsigned LINE_W = WORD_W * WORDS
) (
  input  logic [LINE_W-1:0] line,
  output logic              uniform,
  output logic [WORD_W-1:0] word0
);
  logic [WORDS-1:0] same;

  assign word0 = line[WORD_W-1:0];

  for (genvar i = 0; i < WORDS; i++) begin : g_cmp
    assign same[i] = (line[i*WORD_W +: WORD_W] == word0);
  end

  assign uniform = &same;
endmodule

// File: rtl/uwl_table.sv
module uwl_table #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned TAG_W   = 21,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              lk_valid,
  output logic [TAG_W-1:0]  lk_tag,
  output logic [WORD_W-1:0] lk_word,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx
);
  logic              ent_v   [ENTRIES];
  logic [TAG_W-1:0]  ent_tag [ENTRIES];
  logic [WORD_W-1:0] ent_w   [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_v[e]   <= 1'b0;
        ent_tag[e] <= '0;
        ent_w[e]   <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        ent_v[e]   <= 1'b1;
        ent_tag[e] <= wr_tag;
        ent_w[e]   <= wr_word;
      end else if (inv_en && (inv_idx == IDX_W'(e))) begin
        ent_v[e]   <= 1'b0;
      end
    end
  end

  assign lk_valid = ent_v[lk_idx];
  assign lk_tag   = ent_tag[lk_idx];
  assign lk_word  = ent_w[lk_idx];
endmodule

// File: rtl/uwl_ctrl.sv
module uwl_ctrl
  import uwl_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned WORDS   = 16,
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned LA_W    = 26,
  localparam int unsigned LINE_W = WORD_W * WORDS,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned TAG_W  = LA_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic              up_req_write,
  input  logic [LA_W-1:0]   up_req_addr,
  input  logic [LINE_W-1:0] up_req_data,
  output logic              up_rsp_valid,
  input  logic              up_rsp_ready,
  output logic [LINE_W-1:0] up_rsp_data,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic              dn_req_write,
  output logic [LA_W-1:0]   dn_req_addr,
  output logic [LINE_W-1:0] dn_req_data,
  input  logic              dn_rsp_valid,
  output logic              dn_rsp_ready,
  input  logic [LINE_W-1:0] dn_rsp_data,
  input  logic              uniform,
  input  logic [WORD_W-1:0] uni_word,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic              lk_valid,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [WORD_W-1:0] lk_word,
  output logic              tbl_wr_en,
  output logic [IDX_W-1:0]  tbl_wr_idx,
  output logic [TAG_W-1:0]  tbl_wr_tag,
  output logic [WORD_W-1:0] tbl_wr_word,
  output logic              tbl_inv_en,
  output logic [IDX_W-1:0]  tbl_inv_idx,
  output logic              ev_absorb,
  output logic              ev_evict,
  output logic              ev_hit,
  output logic              in_evict
);
  function automatic logic [LINE_W-1:0] fill_line(input logic [WORD_W-1:0] w);
    logic [LINE_W-1:0] l;
    for (int i = 0; i < WORDS; i++) l[i*WORD_W +: WORD_W] = w;
    return l;
  endfunction

  function automatic logic [IDX_W-1:0] slot_of(input logic [LA_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [LA_W-1:0] a);
    return a[LA_W-1:IDX_W];
  endfunction

  uwl_state_e        state;
  logic [LA_W-1:0]   r_addr;
  logic [LINE_W-1:0] r_line;
  logic [TAG_W-1:0]  r_new_tag;
  logic [WORD_W-1:0] r_new_word;

  logic             acc;
  logic             tag_hit;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic             go_fwd;
  logic             go_rsp;
  logic             go_drd;

  assign req_idx      = slot_of(up_req_addr);
  assign req_tag      = tag_of(up_req_addr);
  assign lk_idx       = req_idx;
  assign up_req_ready = (state == ST_IDLE);
  assign acc          = up_req_valid && up_req_ready;
  assign tag_hit      = lk_valid && (lk_tag == req_tag);
  assign in_evict     = (state == ST_EVICT);

  always_comb begin
    ev_absorb = 1'b0;
    ev_evict  = 1'b0;
    ev_hit    = 1'b0;
    go_fwd    = 1'b0;
    go_rsp    = 1'b0;
    go_drd    = 1'b0;
    if (acc) begin
      if (up_req_write) begin
        if (uniform) begin
          ev_absorb = !lk_valid || tag_hit;
          ev_evict  = lk_valid && !tag_hit;
        end else begin
          go_fwd = 1'b1;
        end
      end else begin
        ev_hit = tag_hit;
        go_rsp = tag_hit;
        go_drd = !tag_hit;
      end
    end
  end

  always_comb begin
    tbl_wr_en   = ev_absorb;
    tbl_wr_idx  = req_idx;
    tbl_wr_tag  = req_tag;
    tbl_wr_word = uni_word;
    if (in_evict && dn_req_ready) begin
      tbl_wr_en   = 1'b1;
      tbl_wr_idx  = slot_of(r_addr);
      tbl_wr_tag  = r_new_tag;
      tbl_wr_word = r_new_word;
    end
  end

  assign tbl_inv_en  = go_fwd && tag_hit;
  assign tbl_inv_idx = req_idx;

  always_comb begin
    dn_req_valid = (state == ST_EVICT) || (state == ST_FWD) || (state == ST_DRD);
    dn_req_write = (state != ST_DRD);
    dn_req_addr  = r_addr;
    dn_req_data  = r_line;
    up_rsp_valid = 1'b0;
    up_rsp_data  = r_line;
    dn_rsp_ready = 1'b0;
    if (state == ST_RSP) begin
      up_rsp_valid = 1'b1;
    end else if (state == ST_WAIT) begin
      up_rsp_valid = dn_rsp_valid;
      up_rsp_data  = dn_rsp_data;
      dn_rsp_ready = up_rsp_ready;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      r_addr     <= '0;
      r_line     <= '0;
      r_new_tag  <= '0;
      r_new_word <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (ev_evict) begin
            state      <= ST_EVICT;
            r_addr     <= {lk_tag, req_idx};
            r_line     <= fill_line(lk_word);
            r_new_tag  <= req_tag;
            r_new_word <= uni_word;
          end else if (go_fwd) begin
            state  <= ST_FWD;
            r_addr <= up_req_addr;
            r_line <= up_req_data;
          end else if (go_rsp) begin
            state  <= ST_RSP;
            r_line <= fill_line(lk_word);
          end else if (go_drd) begin
            state  <= ST_DRD;
            r_addr <= up_req_addr;
          end
        end
        ST_EVICT, ST_FWD: if (dn_req_ready) state <= ST_IDLE;
        ST_DRD:           if (dn_req_ready) state <= ST_WAIT;
        ST_RSP:           if (up_rsp_ready) state <= ST_IDLE;
        ST_WAIT:          if (dn_rsp_valid && up_rsp_ready) state <= ST_IDLE;
        default:          state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uwl_filter.sv
module uwl_filter #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned WORDS   = 16,
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned LA_W    = 26,
  localparam int unsigned LINE_W = WORD_W * WORDS,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned TAG_W  = LA_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic              up_req_write,
  input  logic [LA_W-1:0]   up_req_addr,
  input  logic [LINE_W-1:0] up_req_data,
  output logic              up_rsp_valid,
  input  logic              up_rsp_ready,
  output logic [LINE_W-1:0] up_rsp_data,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic              dn_req_write,
  output logic [LA_W-1:0]   dn_req_addr,
  output logic [LINE_W-1:0] dn_req_data,
  input  logic              dn_rsp_valid,
  output logic              dn_rsp_ready,
  input  logic [LINE_W-1:0] dn_rsp_data
);
  logic              uniform;
  logic [WORD_W-1:0] uni_word;
  logic [IDX_W-1:0]  lk_idx;
  logic              lk_valid;
  logic [TAG_W-1:0]  lk_tag;
  logic [WORD_W-1:0] lk_word;
  logic              tbl_wr_en;
  logic [IDX_W-1:0]  tbl_wr_idx;
  logic [TAG_W-1:0]  tbl_wr_tag;
  logic [WORD_W-1:0] tbl_wr_word;
  logic              tbl_inv_en;
  logic [IDX_W-1:0]  tbl_inv_idx;
  logic              ev_absorb;
  logic              ev_evict;
  logic              ev_hit;
  logic              in_evict;

  uwl_detect #(.WORD_W(WORD_W), .WORDS(WORDS)) u_detect (
    .line    (up_req_data),
    .uniform (uniform),
    .word0   (uni_word)
  );

  uwl_table #(.WORD_W(WORD_W), .ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (lk_idx),
    .lk_valid (lk_valid),
    .lk_tag   (lk_tag),
    .lk_word  (lk_word),
    .wr_en    (tbl_wr_en),
    .wr_idx   (tbl_wr_idx),
    .wr_tag   (tbl_wr_tag),
    .wr_word  (tbl_wr_word),
    .inv_en   (tbl_inv_en),
    .inv_idx  (tbl_inv_idx)
  );

  uwl_ctrl #(.WORD_W(WORD_W), .WORDS(WORDS), .ENTRIES(ENTRIES), .LA_W(LA_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_req_valid (up_req_valid),
    .up_req_ready (up_req_ready),
    .up_req_write (up_req_write),
    .up_req_addr  (up_req_addr),
    .up_req_data  (up_req_data),
    .up_rsp_valid (up_rsp_valid),
    .up_rsp_ready (up_rsp_ready),
    .up_rsp_data  (up_rsp_data),
    .dn_req_valid (dn_req_valid),
    .dn_req_ready (dn_req_ready),
    .dn_req_write (dn_req_write),
    .dn_req_addr  (dn_req_addr),
    .dn_req_data  (dn_req_data),
    .dn_rsp_valid (dn_rsp_valid),
    .dn_rsp_ready (dn_rsp_ready),
    .dn_rsp_data  (dn_rsp_data),
    .uniform      (uniform),
    .uni_word     (uni_word),
    .lk_idx       (lk_idx),
    .lk_valid     (lk_valid),
    .lk_tag       (lk_tag),
    .lk_word      (lk_word),
    .tbl_wr_en    (tbl_wr_en),
    .tbl_wr_idx   (tbl_wr_idx),
    .tbl_wr_tag   (tbl_wr_tag),
    .tbl_wr_word  (tbl_wr_word),
    .tbl_inv_en   (tbl_inv_en),
    .tbl_inv_idx  (tbl_inv_idx),
    .ev_absorb    (ev_absorb),
    .ev_evict     (ev_evict),
    .ev_hit       (ev_hit),
    .in_evict     (in_evict)
  );
endmodule

// File: rtl/uwl_filter_chk.sv
module uwl_filter_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WORDS  = 16,
  parameter int unsigned LA_W   = 26,
  localparam int unsigned LINE_W = WORD_W * WORDS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_req_ready,
  input logic              up_rsp_valid,
  input logic [LINE_W-1:0] up_rsp_data,
  input logic              dn_req_valid,
  input logic              dn_req_ready,
  input logic              dn_req_write,
  input logic [LA_W-1:0]   dn_req_addr,
  input logic [LINE_W-1:0] dn_req_data,
  input logic              ev_absorb,
  input logic              ev_evict,
  input logic              ev_hit,
  input logic              in_evict
);
  function automatic logic all_same(input logic [LINE_W-1:0] l);
    logic s;
    s = 1'b1;
    for (int i = 1; i < WORDS; i++)
      if (l[i*WORD_W +: WORD_W] != l[WORD_W-1:0]) s = 1'b0;
    return s;
  endfunction

  AST_ABSORB_NO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    ev_absorb |=> !dn_req_valid); // R2

  AST_NO_UNIFORM_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid && dn_req_write && !in_evict) |-> !all_same(dn_req_data)); // R2

  AST_HIT_NO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> !dn_req_valid); // R3

  AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> (up_rsp_valid && all_same(up_rsp_data))); // R4

  AST_EVICT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ev_evict |=> (dn_req_valid && dn_req_write && all_same(dn_req_data))); // R6

  AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid && !dn_req_ready) |=>
      (dn_req_valid && $stable(dn_req_write) && $stable(dn_req_addr) && $stable(dn_req_data))); // R9

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid |-> !up_req_ready); // R9
endmodule

bind uwl_filter uwl_filter_chk #(.WORD_W(WORD_W), .WORDS(WORDS), .LA_W(LA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .up_req_ready (up_req_ready),
  .up_rsp_valid (up_rsp_valid),
  .up_rsp_data  (up_rsp_data),
  .dn_req_valid (dn_req_valid),
  .dn_req_ready (dn_req_ready),
  .dn_req_write (dn_req_write),
  .dn_req_addr  (dn_req_addr),
  .dn_req_data  (dn_req_data),
  .ev_absorb    (ev_absorb),
  .ev_evict     (ev_evict),
  .ev_hit       (ev_hit),
  .in_evict     (in_evict)
);

// File: tb/test_uwl_filter.sv
module test_uwl_filter;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned WORDS   = 16;
  localparam int unsigned ENTRIES = 32;
  localparam int unsigned LA_W    = 26;
  localparam int unsigned LINE_W  = WORD_W * WORDS;
  localparam int unsigned CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic              up_req_valid = 1'b0;
  logic              up_req_ready;
  logic              up_req_write = 1'b0;
  logic [LA_W-1:0]   up_req_addr = '0;
  logic [LINE_W-1:0] up_req_data = '0;
  logic              up_rsp_valid;
  logic              up_rsp_ready = 1'b0;
  logic [LINE_W-1:0] up_rsp_data;
  logic              dn_req_valid;
  logic              dn_req_ready = 1'b0;
  logic              dn_req_write;
  logic [LA_W-1:0]   dn_req_addr;
  logic [LINE_W-1:0] dn_req_data;
  logic              dn_rsp_valid = 1'b0;
  logic              dn_rsp_ready;
  logic [LINE_W-1:0] dn_rsp_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uwl_filter #(.WORD_W(WORD_W), .WORDS(WORDS), .ENTRIES(ENTRIES), .LA_W(LA_W)) i_uwl_filter (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit hold_dn = 1'b0;

  // DRAM model
  logic [LINE_W-1:0] dmem [logic [LA_W-1:0]];
  logic [LA_W-1:0]   rq [$];
  int                dwr = 0;
  int                drd = 0;
  logic [LA_W-1:0]   last_wa;
  logic [LINE_W-1:0] last_wd;

  // expected-state model
  logic [LINE_W-1:0] ref_mem [logic [LA_W-1:0]];
  bit                m_val  [ENTRIES];
  int unsigned       m_tag  [ENTRIES];
  logic [WORD_W-1:0] m_word [ENTRIES];

  function automatic bit b_uniform(input logic [LINE_W-1:0] l);
    for (int i = 0; i < WORDS; i++)
      if (l[i*WORD_W +: WORD_W] !== l[WORD_W-1:0]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [LINE_W-1:0] b_fill(input logic [WORD_W-1:0] w);
    logic [LINE_W-1:0] l;
    for (int i = 0; i < WORDS; i++) l[i*WORD_W +: WORD_W] = w;
    return l;
  endfunction

  function automatic logic [LINE_W-1:0] b_rand_line();
    logic [LINE_W-1:0] l;
    for (int i = 0; i < WORDS; i++) l[i*WORD_W +: WORD_W] = $urandom;
    l[2*WORD_W-1:WORD_W] = l[WORD_W-1:0] ^ 32'h1;
    return l;
  endfunction

  task automatic check(input bit ok, input string req, input logic [LINE_W-1:0] act,
                       input logic [LINE_W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    dn_req_ready = hold_dn ? 1'b0 : ($urandom % 4 != 0);
    dn_rsp_valid = (rq.size() > 0);
    if (rq.size() > 0) dn_rsp_data = dmem.exists(rq[0]) ? dmem[rq[0]] : '0;
  end

  always @(posedge clk) begin
    if (dn_req_valid && dn_req_ready) begin
      if (dn_req_write) begin
        dmem[dn_req_addr] = dn_req_data;
        last_wa = dn_req_addr;
        last_wd = dn_req_data;
        dwr++;
      end else begin
        rq.push_back(dn_req_addr);
        drd++;
      end
    end
    if (dn_rsp_valid && dn_rsp_ready) void'(rq.pop_front());
  end

  task automatic issue(input bit wr, input logic [LA_W-1:0] a, input logic [LINE_W-1:0] d);
    bit got;
    @(negedge clk);
    up_req_valid = 1'b1;
    up_req_write = wr;
    up_req_addr  = a;
    up_req_data  = d;
    forever begin
      #1 got = up_req_ready;
      @(posedge clk);
      if (got) break;
      @(negedge clk);
    end
    @(negedge clk);
    up_req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    #1;
    while (!up_req_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  // model update and expected DRAM write for a write-back
  task automatic model_write(input logic [LA_W-1:0] a, input logic [LINE_W-1:0] d,
                             output bit exp_wr, output logic [LA_W-1:0] ea,
                             output logic [LINE_W-1:0] ed);
    int unsigned idx = a % ENTRIES;
    int unsigned tg  = a / ENTRIES;
    if (b_uniform(d)) begin
      exp_wr = m_val[idx] && (m_tag[idx] != tg);
      ea = LA_W'(m_tag[idx] * ENTRIES + idx);
      ed = b_fill(m_word[idx]);
      m_val[idx] = 1'b1; m_tag[idx] = tg; m_word[idx] = d[WORD_W-1:0];
    end else begin
      exp_wr = 1'b1; ea = a; ed = d;
      if (m_val[idx] && m_tag[idx] == tg) m_val[idx] = 1'b0;
    end
    ref_mem[a] = d;
  endtask

  task automatic do_write(input logic [LA_W-1:0] a, input logic [LINE_W-1:0] d, input string req);
    bit exp_wr;
    logic [LA_W-1:0] ea;
    logic [LINE_W-1:0] ed;
    int w0 = dwr;
    model_write(a, d, exp_wr, ea, ed);
    issue(1'b1, a, d);
    wait_idle();
    check((dwr - w0) == (exp_wr ? 1 : 0), {req, " dram write count"},
          LINE_W'(dwr - w0), LINE_W'(exp_wr));
    if (exp_wr) begin
      check(last_wa == ea, {req, " dram write addr"}, LINE_W'(last_wa), LINE_W'(ea));
      check(last_wd == ed, {req, " dram write data"}, last_wd, ed);
    end
  endtask

  task automatic do_read(input logic [LA_W-1:0] a, input string req);
    int unsigned idx = a % ENTRIES;
    bit hit = m_val[idx] && (m_tag[idx] == a / ENTRIES);
    logic [LINE_W-1:0] exp = ref_mem.exists(a) ? ref_mem[a] : '0;
    logic [LINE_W-1:0] got;
    int r0 = drd;
    int lat = 1;
    int first = -1;
    issue(1'b0, a, '0);
    while (1) begin
      up_rsp_ready = ($urandom % 3 != 0);
      #1;
      if (up_rsp_valid && first < 0) first = lat;
      if (up_rsp_valid && up_rsp_ready) begin
        got = up_rsp_data;
        @(posedge clk);
        break;
      end
      @(negedge clk);
      lat++;
    end
    check(got == exp, {req, " read data"}, got, exp);
    check((drd - r0) == (hit ? 0 : 1), hit ? "R3 no dram read on hit" : "R7 miss goes to dram",
          LINE_W'(drd - r0), LINE_W'(hit ? 0 : 1));
    if (hit) check(first == 1, "R4 hit latency", LINE_W'(first), LINE_W'(1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [LINE_W-1:0] l;
    int w0;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < ENTRIES; i++) begin m_val[i] = 0; m_tag[i] = 0; m_word[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R8 reset state
    check(up_req_ready == 1'b1, "R8 ready after reset", LINE_W'(up_req_ready), LINE_W'(1));
    check(up_rsp_valid == 1'b0, "R8 no response after reset", LINE_W'(up_rsp_valid), '0);
    check(dn_req_valid == 1'b0, "R8 no dram request after reset", LINE_W'(dn_req_valid), '0);
    do_read(26'd5, "R8 empty table read");

    // R2 absorb, R3/R4 hit
    do_write(26'd3, b_fill(32'hA5A5_0001), "R2 absorb");
    do_read(26'd3, "R4 rebuilt line");
    do_write(26'd3, b_fill(32'h0000_0007), "R2 same tag update");
    do_read(26'd3, "R2 updated value");

    // R1 one word off, last or first
    l = b_fill(32'h1234_5678); l[LINE_W-1 -: WORD_W] = 32'h1234_5679;
    do_write(26'd4, l, "R1 last word differs");
    l = b_fill(32'h1234_5678); l[WORD_W-1:0] = 32'h0;
    do_write(26'd6, l, "R1 first word differs");

    // R5 invalidate on non-uniform write
    do_write(26'd7, b_fill(32'hDEAD_BEEF), "R2 absorb");
    do_write(26'd7, b_rand_line(), "R5 forward and clear");
    do_read(26'd7, "R5 read after clear");

    // R6 conflict eviction
    do_write(26'd9, b_fill(32'h1111_2222), "R2 absorb");
    do_write(26'd9 + ENTRIES, b_fill(32'h3333_4444), "R6 evict older line");
    do_read(26'd9, "R6 older line from dram");
    do_read(26'd9 + ENTRIES, "R6 new entry hit");

    // R9 back-pressure
    hold_dn = 1'b1;
    l = b_rand_line();
    ref_mem[26'd12] = l;
    w0 = dwr;
    issue(1'b1, 26'd12, l);
    for (int k = 0; k < 3; k++) begin
      #1;
      check(up_req_ready == 1'b0, "R9 no accept while dram pending", LINE_W'(up_req_ready), '0);
      check(dn_req_valid && dn_req_addr == 26'd12 && dn_req_data == l, "R9 request held",
            dn_req_data, l);
      @(negedge clk);
    end
    hold_dn = 1'b0;
    wait_idle();
    check((dwr - w0) == 1, "R9 single write after release", LINE_W'(dwr - w0), LINE_W'(1));

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [LA_W-1:0] a = LA_W'(($urandom % 4) * ENTRIES + ($urandom % 8));
      case ($urandom % 4)
        0: do_write(a, b_fill($urandom % 3), "R2 R6 random uniform");
        1: do_write(a, b_rand_line(), "R5 random non-uniform");
        default: do_read(a, "R7 random read");
      endcase
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule